// File: doc/BRIEF.md
# Level-Based Interrupt Acceptance Stage

This block sits inside a processor core. It decides whether the core takes a trap in the current cycle. An interrupt controller outside the core does the arbitration. It hands this block one winning request per cycle. The request carries an identifier, an 8-bit level, a privilege field and a flag asking for hardware table vectoring.

The block ranks the two non-maskable bus-fault interrupts above that request. It admits the request only when all of the following hold:
- the core is ready;
- the core is not halted for debug;
- the global enable is set;
- the vector-base mode selects this architecture;
- the request's level is strictly above the level of the handler that is running.

When a trap is taken, the block reports:
- the cause code;
- whether the trap is non-maskable;
- the handler target, or a request to fetch the handler's address from the vector table.

The block holds the current and previous interrupt levels itself. It updates them on an accepted request and restores the current level on a return from the handler.

Top module: `clic_accept`

## Requirements
- R1: After reset both the current level and the previous level read 0. No request is taken while the global enable input is 0.
- R2: An external request is taken only when all of these hold: the request line is 1, the global enable is 1, `vecMode` equals 2'b11, `extPriv` equals 2'b11 and `coreReady` is 1. A change on any one of these inputs blocks acceptance on its own.
- R3: An external request is taken only when its level is strictly greater than the current level. A request whose level equals the current level is not taken.
- R4: When an external request is taken, `trapTake` is 1, `trapIsNmi` is 0 and `trapCause` equals the identifier zero-extended to 11 bits. After the next clock edge, the previous level holds the old current level and the current level holds the request's level.
- R5: A pulse on `mretReq` copies the previous level into the current level at the next edge. The previous level is left unchanged.
- R6: A store-fault NMI (cause 1025) outranks a load-fault NMI (cause 1024). Either NMI outranks any external request. `trapIsNmi` is 1 for both.
- R7: NMIs are taken regardless of the global enable and of `vecMode`. Taking an NMI leaves both level registers unchanged.
- R8: While `debugMode` is 1, nothing is taken, NMIs included.
- R9: For an external trap with the vectoring flag set, `tableFetch` is 1 and `tableFetchAddr` equals `tableBase` plus 4 times the identifier. With the flag clear, `tableFetch` is 0 and `handlerAddr` equals `{vecBaseHi, 6'b0}`.
- R10: For an NMI, `handlerAddr` equals `{vecBaseHi[25:1], 7'b0}`, which is slot 0 of the vector table, and `tableFetch` is 0.
- R11: No trap is taken in a cycle in which `mretReq` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| extReq | input | 1 | External controller has a pending, enabled request (level-sensitive) |
| extId | input | ID_W | Identifier of that request |
| extLevel | input | 8 | Level of that request |
| extPriv | input | 2 | Privilege of that request; only 2'b11 is accepted |
| extHwVec | input | 1 | Request wants hardware table vectoring |
| nmiLoad | input | 1 | Load bus-fault NMI pending |
| nmiStore | input | 1 | Store bus-fault NMI pending |
| gie | input | 1 | Global machine interrupt enable |
| debugMode | input | 1 | Core is halted in debug mode |
| coreReady | input | 1 | Pipeline can accept a trap this cycle |
| mretReq | input | 1 | Return from handler executes this cycle |
| vecBaseHi | input | 26 | Trap vector base, address bits 31:6 |
| vecMode | input | 2 | Trap vector mode bits |
| tableBase | input | 32 | Base address of the handler-address table |
| trapTake | output | 1 | A trap is taken this cycle |
| trapIsNmi | output | 1 | The trap taken is an NMI |
| trapCause | output | 11 | Cause code of the trap |
| tableFetch | output | 1 | Fetch the handler address from the table |
| tableFetchAddr | output | 32 | Address of the table entry |
| handlerAddr | output | 32 | Direct handler target |
| curLevel | output | 8 | Level of the running handler |
| prevLevel | output | 8 | Saved level, restored on return |

## Verification
The hardest state to reach is the one where the current level is already raised. Only then does strict-greater preemption differ from plain acceptance, and only then does a return have a non-zero level to restore. The stimulus gets there by taking a level-10 request, then offering an equal-level request, which must be refused, and then a level-11 request, which must be accepted. Returns then drop the level back to 10. The bench also raises an NMI while the level is non-zero, to show that the NMI leaves the level registers untouched. Finally, it offers a high-level request in the same cycle as a return, which must be refused.

// File: rtl/clic_accept_pkg.sv
package clic_accept_pkg;
  localparam int LEVEL_W = 8;
  localparam int CAUSE_W = 11;
  localparam int ADDR_W  = 32;
  localparam logic [CAUSE_W-1:0] CAUSE_NMI_LOAD  = 11'd1024;
  localparam logic [CAUSE_W-1:0] CAUSE_NMI_STORE = 11'd1025;
  localparam logic [1:0] MODE_LEVELED = 2'b11;
  localparam logic [1:0] PRIV_MACHINE = 2'b11;

  typedef struct packed {
    logic takeExt;
    logic takeNmi;
    logic nmiStore;
    logic mret;
  } strobe_t;
endpackage

// File: rtl/clic_accept_ctrl.sv
module clic_accept_ctrl
  import clic_accept_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       extReq,
  input  logic [1:0] extPriv,
  input  logic       nmiLoad,
  input  logic       nmiStore,
  input  logic       gie,
  input  logic       debugMode,
  input  logic       coreReady,
  input  logic       mretReq,
  input  logic [1:0] vecMode,
  input  logic       levelWins,
  output strobe_t    strb
);
  logic canTrap;
  logic nmiAny;
  logic extOk;

  always_comb begin
    canTrap = coreReady && !debugMode && !mretReq;
    nmiAny  = nmiLoad || nmiStore;
    extOk   = extReq && gie && (vecMode == MODE_LEVELED) &&
              (extPriv == PRIV_MACHINE) && levelWins;
    strb.takeNmi  = canTrap && nmiAny;
    strb.takeExt  = canTrap && !nmiAny && extOk;
    strb.nmiStore = nmiStore;
    strb.mret     = mretReq;
  end

  p_one_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.takeExt && strb.takeNmi));
  p_debug_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    debugMode |-> !(strb.takeExt || strb.takeNmi));
  p_mret_blocks_r11: assert property (@(posedge clk) disable iff (!rstN)
    mretReq |-> !(strb.takeExt || strb.takeNmi));
endmodule

// File: rtl/clic_accept_dp.sv
module clic_accept_dp
  import clic_accept_pkg::*;
#(
  parameter int ID_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [ID_W-1:0]    extId,
  input  logic [LEVEL_W-1:0] extLevel,
  input  logic               extHwVec,
  input  logic [25:0]        vecBaseHi,
  input  logic [ADDR_W-1:0]  tableBase,
  output logic               levelWins,
  output logic [CAUSE_W-1:0] trapCause,
  output logic               tableFetch,
  output logic [ADDR_W-1:0]  tableFetchAddr,
  output logic [ADDR_W-1:0]  handlerAddr,
  output logic [LEVEL_W-1:0] curLevel,
  output logic [LEVEL_W-1:0] prevLevel
);
  logic [LEVEL_W-1:0] curQ, prevQ;
  logic [ADDR_W-1:0]  idOffset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curQ  <= '0;
      prevQ <= '0;
    end else if (strb.takeExt) begin
      prevQ <= curQ;
      curQ  <= extLevel;
    end else if (strb.mret) begin
      curQ  <= prevQ;
    end
  end

  always_comb begin
    levelWins = extLevel > curQ;
    idOffset  = ADDR_W'(extId) << 2;
    tableFetchAddr = tableBase + idOffset;
    tableFetch = strb.takeExt && extHwVec;
    if (strb.takeNmi) begin
      trapCause   = strb.nmiStore ? CAUSE_NMI_STORE : CAUSE_NMI_LOAD;
      handlerAddr = {vecBaseHi[25:1], 7'b0};
    end else begin
      trapCause   = CAUSE_W'(extId);
      handlerAddr = {vecBaseHi, 6'b0};
    end
    curLevel  = curQ;
    prevLevel = prevQ;
  end

  p_nmi_level_kept_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeNmi |=> ($stable(curQ) && $stable(prevQ)));
  p_ext_level_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeExt |=> (curQ == $past(extLevel) && prevQ == $past(curQ)));
  p_mret_restore_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.mret && !strb.takeExt) |=> (curQ == $past(prevQ) && $stable(prevQ)));
endmodule

// File: rtl/clic_accept.sv
module clic_accept
  import clic_accept_pkg::*;
#(
  parameter int ID_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                extReq,
  input  logic [ID_W-1:0]     extId,
  input  logic [7:0]          extLevel,
  input  logic [1:0]          extPriv,
  input  logic                extHwVec,
  input  logic                nmiLoad,
  input  logic                nmiStore,
  input  logic                gie,
  input  logic                debugMode,
  input  logic                coreReady,
  input  logic                mretReq,
  input  logic [25:0]         vecBaseHi,
  input  logic [1:0]          vecMode,
  input  logic [31:0]         tableBase,
  output logic                trapTake,
  output logic                trapIsNmi,
  output logic [10:0]         trapCause,
  output logic                tableFetch,
  output logic [31:0]         tableFetchAddr,
  output logic [31:0]         handlerAddr,
  output logic [7:0]          curLevel,
  output logic [7:0]          prevLevel
);
  strobe_t strb;
  logic    levelWins;

  clic_accept_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .extReq(extReq), .extPriv(extPriv),
    .nmiLoad(nmiLoad), .nmiStore(nmiStore), .gie(gie),
    .debugMode(debugMode), .coreReady(coreReady), .mretReq(mretReq),
    .vecMode(vecMode), .levelWins(levelWins), .strb(strb)
  );

  clic_accept_dp #(.ID_W(ID_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .extId(extId),
    .extLevel(extLevel), .extHwVec(extHwVec), .vecBaseHi(vecBaseHi),
    .tableBase(tableBase), .levelWins(levelWins), .trapCause(trapCause),
    .tableFetch(tableFetch), .tableFetchAddr(tableFetchAddr),
    .handlerAddr(handlerAddr), .curLevel(curLevel), .prevLevel(prevLevel)
  );

  assign trapTake  = strb.takeExt || strb.takeNmi;
  assign trapIsNmi = strb.takeNmi;

  p_ext_strictly_higher_r3: assert property (@(posedge clk) disable iff (!rstN)
    (trapTake && !trapIsNmi) |-> (extLevel > curLevel));
  p_ext_needs_enable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (trapTake && !trapIsNmi) |-> (gie && extReq && vecMode == 2'b11 && extPriv == 2'b11));
  p_nmi_no_fetch_r10: assert property (@(posedge clk) disable iff (!rstN)
    trapIsNmi |-> (!tableFetch && trapCause[10]));
  p_store_first_r6: assert property (@(posedge clk) disable iff (!rstN)
    (trapIsNmi && nmiStore) |-> (trapCause == 11'd1025));
endmodule

// File: tb/clic_accept_bench.sv
module clic_accept_bench;
  logic clk = 1'b0;
  logic rstN;
  logic extReq, extHwVec, nmiLoad, nmiStore, gie, debugMode, coreReady, mretReq;
  logic [9:0] extId;
  logic [7:0] extLevel;
  logic [1:0] extPriv, vecMode;
  logic [25:0] vecBaseHi;
  logic [31:0] tableBase;
  logic trapTake, trapIsNmi, tableFetch;
  logic [10:0] trapCause;
  logic [31:0] tableFetchAddr, handlerAddr;
  logic [7:0] curLevel, prevLevel;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  clic_accept u_clic_accept (
    .clk(clk), .rstN(rstN), .extReq(extReq), .extId(extId), .extLevel(extLevel),
    .extPriv(extPriv), .extHwVec(extHwVec), .nmiLoad(nmiLoad), .nmiStore(nmiStore),
    .gie(gie), .debugMode(debugMode), .coreReady(coreReady), .mretReq(mretReq),
    .vecBaseHi(vecBaseHi), .vecMode(vecMode), .tableBase(tableBase),
    .trapTake(trapTake), .trapIsNmi(trapIsNmi), .trapCause(trapCause),
    .tableFetch(tableFetch), .tableFetchAddr(tableFetchAddr),
    .handlerAddr(handlerAddr), .curLevel(curLevel), .prevLevel(prevLevel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    extReq = 0; extId = '0; extLevel = '0; extPriv = 2'b11; extHwVec = 0;
    nmiLoad = 0; nmiStore = 0; gie = 1; debugMode = 0; coreReady = 1;
    mretReq = 0; vecMode = 2'b11;
  endtask

  // drive at negedge, look at combinational outputs 1 ns later
  task automatic offer(input logic [9:0] id, input logic [7:0] lvl, input logic hv);
    @(negedge clk);
    extReq = 1; extId = id; extLevel = lvl; extHwVec = hv;
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic t_reset();
    chk("R1 cur", 32'(curLevel), 0);
    chk("R1 prev", 32'(prevLevel), 0);
    gie = 0;
    offer(10'd3, 8'd5, 0);
    chk("R1 gie off", 32'(trapTake), 0);
    settle();
    chk("R1 level stays", 32'(curLevel), 0);
  endtask

  task automatic t_take();
    offer(10'd37, 8'd10, 0);
    chk("R4 take", 32'(trapTake), 1);
    chk("R4 notnmi", 32'(trapIsNmi), 0);
    chk("R4 cause", 32'(trapCause), 37);
    chk("R9 nofetch", 32'(tableFetch), 0);
    chk("R9 common", handlerAddr, 32'h0000_2040);
    settle();
    chk("R4 cur", 32'(curLevel), 10);
    chk("R4 prev", 32'(prevLevel), 0);
  endtask

  task automatic t_preempt();
    offer(10'd9, 8'd10, 0);
    chk("R3 equal refused", 32'(trapTake), 0);
    settle();
    offer(10'd5, 8'd11, 1);
    chk("R3 higher taken", 32'(trapTake), 1);
    chk("R9 fetch", 32'(tableFetch), 1);
    chk("R9 fetch addr", tableFetchAddr, 32'h8000_0414);
    settle();
    chk("R3 cur", 32'(curLevel), 11);
    chk("R3 prev", 32'(prevLevel), 10);
  endtask

  task automatic t_mret();
    @(negedge clk); mretReq = 1; #1;
    settle();
    chk("R5 cur restored", 32'(curLevel), 10);
    chk("R5 prev kept", 32'(prevLevel), 10);
    @(negedge clk); mretReq = 1; extReq = 1; extLevel = 8'd200; extId = 10'd1; #1;
    chk("R11 no take on mret", 32'(trapTake), 0);
    settle();
    chk("R11 level", 32'(curLevel), 10);
  endtask

  task automatic t_gating();
    @(negedge clk); extPriv = 2'b01; extReq = 1; extLevel = 8'd250; #1;
    chk("R2 priv", 32'(trapTake), 0);
    extPriv = 2'b11; vecMode = 2'b00; #1;
    chk("R2 mode", 32'(trapTake), 0);
    vecMode = 2'b11; coreReady = 0; #1;
    chk("R2 ready", 32'(trapTake), 0);
    settle();
    chk("R2 level kept", 32'(curLevel), 10);
  endtask

  task automatic t_nmi();
    @(negedge clk); gie = 0; vecMode = 2'b00; nmiLoad = 1; #1;
    chk("R7 nmi taken", 32'(trapTake), 1);
    chk("R6 nmi flag", 32'(trapIsNmi), 1);
    chk("R6 load cause", 32'(trapCause), 1024);
    chk("R10 slot0", handlerAddr, 32'h0000_2000);
    chk("R10 nofetch", 32'(tableFetch), 0);
    settle();
    chk("R7 cur kept", 32'(curLevel), 10);
    chk("R7 prev kept", 32'(prevLevel), 10);
    @(negedge clk); nmiLoad = 1; nmiStore = 1; extReq = 1; extLevel = 8'd255; extHwVec = 1; #1;
    chk("R6 store first", 32'(trapCause), 1025);
    chk("R6 over ext", 32'(trapIsNmi), 1);
    settle();
    chk("R6 level kept", 32'(curLevel), 10);
  endtask

  task automatic t_debug();
    @(negedge clk); debugMode = 1; nmiStore = 1; extReq = 1; extLevel = 8'd255; #1;
    chk("R8 debug blocks", 32'(trapTake), 0);
    settle();
    chk("R8 level", 32'(curLevel), 10);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    vecBaseHi = 26'h0000081;
    tableBase = 32'h8000_0400;
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    t_reset();
    idle();
    t_take();
    t_preempt();
    t_mret();
    t_gating();
    t_nmi();
    t_debug();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule